// File: doc/BRIEF.md
# Short-Frame PCM Serial Port

This block is the serial side of a telephony voice codec that frames its data with short, one-bit-wide sync pulses. It has a transmit path and a receive path. Each frame, the transmit path sends one 8-bit companded sample out on a data pin that can be tri-stated. The receive path collects one 8-bit sample per frame from the incoming data pin. The two directions may run from independent bit clocks anywhere between 64 kHz and 2.048 MHz. A mode input can instead make the receive path follow the transmit bit clock.

The block never uses the bit clocks as clocks. Both bit clocks, both frame syncs and the incoming data are oversampled by a system clock that runs at least four times faster than the fastest bit clock. They pass through two-flop synchronizers, and their edges are found in logic. Upstream logic writes the next sample into a holding register. A ready pulse reports the moment that word has been taken into a frame. Downstream logic receives each complete word with a one-cycle valid strobe. The pad driver is outside this block: it drives the data pin from `dout` while `dout_oe` is high and leaves the pin floating otherwise.

Top module: `pcm_sf_port`

## Requirements
- R1: After reset, `dout_oe`, `tx_ready`, `rx_valid`, `err_tx` and `err_rx` are 0 and `rx_word` is 0. The port starts in short-frame operation, in which each sync pulse spans one bit-clock period.
- R2: A transmit frame begins when `fs_tx` is high at a falling edge of `bclk_tx`. On the next rising edge, `dout_oe` goes high and `dout` carries the sign bit, which is bit 7 of the word.
- R3: Each of the following seven rising edges of `bclk_tx` puts the next lower bit on `dout`, so the word goes out MSB first. `dout` changes on no other event.
- R4: At the falling edge of `bclk_tx` that ends the eighth bit, `dout_oe` returns to 0. With no frame sync, a toggling bit clock never raises `dout_oe`.
- R5: A receive frame begins when the receive frame sync is high at a falling edge of the receive bit clock. The next eight falling edges latch `din` MSB first. After the eighth, `rx_word` holds the word and `rx_valid` is high for exactly one system-clock cycle.
- R6: With `sync_mode` = 1 the receive side counts edges of `bclk_tx` and ignores `bclk_rx`. With `sync_mode` = 0 it uses `bclk_rx` only.
- R7: A one-cycle `tx_load` pulse writes `tx_word` into the holding register. The holding register is copied into the shifter when the transmit frame begins, and at that moment `tx_ready` pulses high for one cycle.
- R8: A frame sync that arrives while a word is unfinished restarts that side's frame from the sign bit and sets that side's error flag (`err_tx` or `err_rx`). The flag stays set until reset.
- R9: A frame sync seen at the same falling edge that completes the eighth bit starts the next frame back to back. The finished word is still delivered, and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the fastest bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: receive side uses the transmit bit clock |
| bclk_tx | input | 1 | Transmit bit clock |
| fs_tx | input | 1 | Transmit frame sync, one bit period wide |
| bclk_rx | input | 1 | Receive bit clock |
| fs_rx | input | 1 | Receive frame sync, one bit period wide |
| tx_word | input | 8 | Next transmit sample |
| tx_load | input | 1 | Writes `tx_word` into the holding register |
| tx_ready | output | 1 | One-cycle pulse when a frame takes the held word |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for the tri-state data pad |
| din | input | 1 | Serial receive data |
| rx_word | output | 8 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| err_tx | output | 1 | Sticky: transmit frame restarted mid-word |
| err_rx | output | 1 | Sticky: receive frame restarted mid-word |

## Verification
The bench loops the transmit pin back to the receive pin in synchronous mode and sends all 256 word values. It checks every bit on the pin just before the edge where the receiver latches it. A design that shifted LSB first or enabled the pad one edge late would show a wrong bit or a floating pin. Back-to-back frames, with the sync pulse on the last bit, catch a design that raises a spurious error or drops the finished word. A sync pulse in the middle of a word must restart both sides on the new word and set both sticky flags. A design that carried on with the old word, or cleared the flag on the next good frame, fails there. In the asynchronous test the bench toggles the transmit clock during a receive sync pulse and expects no valid strobe. It then receives words on the separate receive clock. This catches a design that picks the wrong receive clock.

// File: rtl/pcm_sf_pkg.sv
package pcm_sf_pkg;

    localparam int WORD_W      = 8;
    localparam int SYNC_STAGES = 2;

    // Raw pins sampled into the system-clock domain, in one bundle
    typedef struct packed {
        logic din;
        logic fs_rx;
        logic fs_tx;
        logic bclk_rx;
        logic bclk_tx;
    } pin_bundle_t;

    localparam int PIN_W = $bits(pin_bundle_t);

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_t;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_t;

    // Width of a bit counter that reaches w-1
    function automatic int cnt_width(input int w);
        return (w > 2) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/pcm_sf_sync.sv
module pcm_sf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign level_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcm_sf_tx.sv
module pcm_sf_tx
    import pcm_sf_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_rise,
    input  logic         bit_fall,
    input  logic         fs_lvl,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    output logic         ready_o,
    output logic         dout_o,
    output logic         oe_o,
    output logic         err_o
);
    localparam int CW = cnt_width(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    tx_state_t     state_q;
    logic [W-1:0]  hold_q;
    logic [W-1:0]  shift_q;
    logic [CW-1:0] cnt_q;
    logic          dout_q, oe_q, ready_q, err_q;

    always_ff @(posedge clk) begin
        if (rst)         hold_q <= '0;
        else if (load_i) hold_q <= word_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            shift_q <= '0;
            cnt_q   <= '0;
            dout_q  <= 1'b0;
            oe_q    <= 1'b0;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            ready_q <= 1'b0;
            if (bit_fall) begin
                if (state_q == TX_SHIFT && cnt_q == LAST) begin
                    oe_q    <= 1'b0;
                    state_q <= TX_IDLE;
                end
                if (fs_lvl) begin
                    if (state_q == TX_ARMED || (state_q == TX_SHIFT && cnt_q != LAST))
                        err_q <= 1'b1;
                    oe_q    <= 1'b0;
                    shift_q <= hold_q;
                    ready_q <= 1'b1;
                    cnt_q   <= '0;
                    state_q <= TX_ARMED;
                end
            end else if (bit_rise) begin
                case (state_q)
                    TX_ARMED: begin
                        oe_q    <= 1'b1;
                        dout_q  <= shift_q[W-1];
                        shift_q <= shift_q << 1;
                        cnt_q   <= '0;
                        state_q <= TX_SHIFT;
                    end
                    TX_SHIFT: begin
                        if (cnt_q != LAST) begin
                            dout_q  <= shift_q[W-1];
                            shift_q <= shift_q << 1;
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign dout_o  = dout_q;
    assign oe_o    = oe_q;
    assign ready_o = ready_q;
    assign err_o   = err_q;

    AST_TX_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        ready_q |=> !ready_q); // R7
    AST_OE_OPENS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> $past(bit_rise)); // R2
    AST_OE_ONLY_ON_EDGES: assert property (@(posedge clk) disable iff (rst)
        (!bit_rise && !bit_fall) |=> $stable(oe_q)); // R4
    AST_DOUT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !bit_rise |=> $stable(dout_q)); // R3
    AST_TX_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R8

endmodule

// File: rtl/pcm_sf_rx.sv
module pcm_sf_rx
    import pcm_sf_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_fall,
    input  logic         fs_lvl,
    input  logic         din_lvl,
    output logic [W-1:0] word_o,
    output logic         valid_o,
    output logic         err_o
);
    localparam int CW = cnt_width(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    rx_state_t     state_q;
    logic [W-1:0]  shift_q;
    logic [W-1:0]  word_q;
    logic [CW-1:0] cnt_q;
    logic          valid_q, err_q;
    logic [W-1:0]  shift_nx;

    assign shift_nx = {shift_q[W-2:0], din_lvl};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            shift_q <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (bit_fall) begin
                if (state_q == RX_RECV) begin
                    shift_q <= shift_nx;
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        word_q  <= shift_nx;
                        valid_q <= 1'b1;
                        state_q <= RX_IDLE;
                    end
                end
                if (fs_lvl) begin
                    if (state_q == RX_RECV && cnt_q != LAST)
                        err_q <= 1'b1;
                    cnt_q   <= '0;
                    state_q <= RX_RECV;
                end
            end
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R5
    AST_RX_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(bit_fall)); // R5
    AST_RX_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(word_q)); // R5
    AST_RX_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R8

endmodule

// File: rtl/pcm_sf_port.sv
module pcm_sf_port
    import pcm_sf_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sync_mode,
    input  logic         bclk_tx,
    input  logic         fs_tx,
    input  logic         bclk_rx,
    input  logic         fs_rx,
    input  logic [W-1:0] tx_word,
    input  logic         tx_load,
    output logic         tx_ready,
    output logic         dout,
    output logic         dout_oe,
    input  logic         din,
    output logic [W-1:0] rx_word,
    output logic         rx_valid,
    output logic         err_tx,
    output logic         err_rx
);
    pin_bundle_t raw_pins, syn_pins;
    logic        prev_btx, prev_brx;
    logic        tx_rise, tx_fall, rxclk_fall, rx_fall;

    assign raw_pins = '{din: din, fs_rx: fs_rx, fs_tx: fs_tx,
                        bclk_rx: bclk_rx, bclk_tx: bclk_tx};

    pcm_sf_sync #(.W(PIN_W), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_pins),
        .level_o (syn_pins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_btx <= 1'b0;
            prev_brx <= 1'b0;
        end else begin
            prev_btx <= syn_pins.bclk_tx;
            prev_brx <= syn_pins.bclk_rx;
        end
    end

    assign tx_rise    =  syn_pins.bclk_tx & ~prev_btx;
    assign tx_fall    = ~syn_pins.bclk_tx &  prev_btx;
    assign rxclk_fall = ~syn_pins.bclk_rx &  prev_brx;
    assign rx_fall    = sync_mode ? tx_fall : rxclk_fall;

    pcm_sf_tx #(.W(W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .bit_rise (tx_rise),
        .bit_fall (tx_fall),
        .fs_lvl   (syn_pins.fs_tx),
        .load_i   (tx_load),
        .word_i   (tx_word),
        .ready_o  (tx_ready),
        .dout_o   (dout),
        .oe_o     (dout_oe),
        .err_o    (err_tx)
    );

    pcm_sf_rx #(.W(W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .bit_fall (rx_fall),
        .fs_lvl   (syn_pins.fs_rx),
        .din_lvl  (syn_pins.din),
        .word_o   (rx_word),
        .valid_o  (rx_valid),
        .err_o    (err_rx)
    );

    AST_TX_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(tx_rise && tx_fall)); // R3
    AST_RX_CLOCK_SELECT: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !tx_fall) |-> !rx_fall); // R6

endmodule

// File: tb/tb_pcm_sf_port.sv
`timescale 1ns/1ps
module tb_pcm_sf_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_TX    = 80;
    localparam int HALF_RX    = 110;

    logic       clk = 1'b0;
    logic       rst, sync_mode, bclk_tx, fs_tx, bclk_rx, fs_rx, tx_load;
    logic [7:0] tx_word;
    logic       tx_ready, dout, dout_oe, din, rx_valid, err_tx, err_rx;
    logic [7:0] rx_word;
    logic       loopback, din_drv;

    int n_chk = 0, n_err = 0, n_ready = 0, n_valid = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign din = loopback ? (dout_oe ? dout : 1'b1) : din_drv;

    pcm_sf_port dut (
        .clk(clk), .rst(rst), .sync_mode(sync_mode),
        .bclk_tx(bclk_tx), .fs_tx(fs_tx), .bclk_rx(bclk_rx), .fs_rx(fs_rx),
        .tx_word(tx_word), .tx_load(tx_load), .tx_ready(tx_ready),
        .dout(dout), .dout_oe(dout_oe), .din(din),
        .rx_word(rx_word), .rx_valid(rx_valid),
        .err_tx(err_tx), .err_rx(err_rx)
    );

    always @(posedge clk) begin
        if (!rst && tx_ready) n_ready++;
        if (!rst && rx_valid) n_valid++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_word(input logic [7:0] v);
        @(negedge clk);
        tx_word = v;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // One transmit bit period; pin checked just before the falling edge
    task automatic tick(input logic f, input bit c_oe, input logic e_oe,
                        input bit c_d, input logic e_d, input string req);
        bclk_tx = 1'b1;
        fs_tx   = f;
        fs_rx   = f;
        #(HALF_TX - 1);
        if (c_oe) check(dout_oe == e_oe, req, "dout_oe", dout_oe, e_oe);
        if (c_d)  check(dout == e_d, req, "dout", dout, e_d);
        #1;
        bclk_tx = 1'b0;
        #HALF_TX;
    endtask

    task automatic rtick(input logic f, input logic d);
        bclk_rx = 1'b1;
        fs_rx   = f;
        din_drv = d;
        #HALF_RX;
        bclk_rx = 1'b0;
        #HALF_RX;
    endtask

    task automatic send_frame(input logic [7:0] v);
        tick(1'b1, 1, 1'b0, 0, 1'b0, "R2");
        for (int i = 1; i <= 8; i++)
            tick(1'b0, 1, 1'b1, 1, v[8-i], (i == 1) ? "R2" : "R3");
        tick(1'b0, 1, 1'b0, 0, 1'b0, "R4");
        check(rx_word == v, "R5", "rx_word", rx_word, v);
    endtask

    initial begin
        rst = 1'b1; sync_mode = 1'b1; bclk_tx = 1'b0; fs_tx = 1'b0;
        bclk_rx = 1'b0; fs_rx = 1'b0; tx_load = 1'b0; tx_word = '0;
        loopback = 1'b1; din_drv = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        check(dout_oe == 0, "R1", "dout_oe", dout_oe, 0);
        check(tx_ready == 0, "R1", "tx_ready", tx_ready, 0);
        check(rx_valid == 0, "R1", "rx_valid", rx_valid, 0);
        check(err_tx == 0 && err_rx == 0, "R1", "errors", {err_tx, err_rx}, 0);
        check(rx_word == 0, "R1", "rx_word", rx_word, 0);

        // R4: clock without sync never opens the pad
        load_word(8'hFF);
        for (int i = 0; i < 4; i++) tick(1'b0, 1, 1'b0, 0, 1'b0, "R4");
        check(n_ready == 0, "R7", "ready without sync", n_ready, 0);

        // Full sweep in loopback, synchronous mode (R6: bclk_rx held low)
        for (int v = 0; v < 256; v++) begin
            load_word(8'(v));
            send_frame(8'(v));
        end
        check(n_ready == 256, "R7", "tx_ready pulses", n_ready, 256);
        check(n_valid == 256, "R5", "rx_valid pulses", n_valid, 256);
        check(n_valid == 256, "R6", "rx on tx clock", n_valid, 256);
        check(err_tx == 0 && err_rx == 0, "R8", "no error", {err_tx, err_rx}, 0);

        // R9 back to back: sync during the last bit
        load_word(8'hA5);
        tick(1'b1, 1, 1'b0, 0, 1'b0, "R9");
        load_word(8'h3C);
        for (int i = 1; i <= 7; i++) tick(1'b0, 1, 1'b1, 1, 8'hA5 >> (8-i), "R9");
        tick(1'b1, 1, 1'b1, 1, 1'b1, "R9");
        check(rx_word == 8'hA5, "R9", "first word", rx_word, 8'hA5);
        for (int i = 1; i <= 8; i++) tick(1'b0, 1, 1'b1, 1, 1'((8'h3C >> (8-i)) & 1), "R9");
        tick(1'b0, 1, 1'b0, 0, 1'b0, "R9");
        check(rx_word == 8'h3C, "R9", "second word", rx_word, 8'h3C);
        check(err_tx == 0 && err_rx == 0, "R9", "no error", {err_tx, err_rx}, 0);

        // R8 restart in the middle of a word
        load_word(8'h81);
        tick(1'b1, 1, 1'b0, 0, 1'b0, "R8");
        tick(1'b0, 1, 1'b1, 1, 1'b1, "R8");
        tick(1'b0, 1, 1'b1, 1, 1'b0, "R8");
        load_word(8'h7E);
        tick(1'b1, 1, 1'b1, 1, 1'b0, "R8");
        for (int i = 1; i <= 8; i++) tick(1'b0, 1, 1'b1, 1, 1'((8'h7E >> (8-i)) & 1), "R8");
        tick(1'b0, 1, 1'b0, 0, 1'b0, "R8");
        check(rx_word == 8'h7E, "R8", "restarted word", rx_word, 8'h7E);
        check(err_tx == 1, "R8", "err_tx", err_tx, 1);
        check(err_rx == 1, "R8", "err_rx", err_rx, 1);
        load_word(8'h5A);
        send_frame(8'h5A);
        check(err_tx == 1 && err_rx == 1, "R8", "sticky", {err_tx, err_rx}, 3);

        // Reset clears the flags
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(err_tx == 0 && err_rx == 0, "R1", "flags after reset", {err_tx, err_rx}, 0);

        // R6 asynchronous mode: transmit clock must not drive the receiver
        sync_mode = 1'b0;
        loopback  = 1'b0;
        n_valid   = 0;
        tick(1'b1, 0, 1'b0, 0, 1'b0, "R6");
        for (int i = 0; i < 10; i++) tick(1'b0, 0, 1'b0, 0, 1'b0, "R6");
        check(n_valid == 0, "R6", "rx ignores bclk_tx", n_valid, 0);

        for (int k = 0; k < 16; k++) begin
            logic [7:0] w;
            w = 8'(k * 37 + 11);
            rtick(1'b1, 1'b0);
            for (int i = 1; i <= 8; i++) rtick(1'b0, w[8-i]);
            rtick(1'b0, 1'b1);
            check(rx_word == w, "R6", "async rx_word", rx_word, w);
        end
        check(n_valid == 16, "R5", "async valid pulses", n_valid, 16);
        check(err_rx == 0, "R8", "async no error", err_rx, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule